// File: doc/BRIEF.md
# Display Control Register Decoder

This block sits behind the control port of a graphics engine. Each 32-bit word written to the port carries a command number in its top byte and operands below it. The decoder keeps the display state. That state covers blanking, the transfer direction, the display origin, the horizontal and vertical display ranges and the video mode. From it the block derives a packed status word and the visible width and height of the picture.

Query commands load a read-back register from the drawing-environment registers, which enter as inputs. A full reset command and a command-buffer reset command each produce a one-cycle pulse for the logic around the block. A write that repeats the last accepted word of a state-holding command is dropped.

The visible width needs a scaled division, so the geometry is recomputed by a short sequence after each range or mode write. A busy flag covers that sequence.

Top module: `dpy_ctrl_dec`

## Requirements
- R1: After hardware reset or an accepted command 0x00 (command number in bits 31:24), the status word is 0x14802000, the read-back word is 0, the display origin is (0,0), the width is 256, the height is 240 and busy is low one cycle later.
- R2: Command 0x01 raises cmdBufRstPulse for exactly one cycle, the cycle after the write, and leaves the status word unchanged. Command 0x00 raises both softRstPulse and cmdBufRstPulse for that cycle.
- R3: Command 0x03 copies data bit 0 to status bit 23 (blanking). Command 0x04 copies data bits 1:0 to status bits 30:29 (transfer direction).
- R4: Command 0x05 loads display X from data bits 9:0 and display Y from data bits 18:10. Data bits 23:19 are ignored.
- R5: Command 0x08 writes data bits 5:0 to status bits 22:17 and data bit 6 to status bit 16. Status bits 18:16 select the horizontal resolution from {256,368,320,384,512,512,640,640}. Status bits 20:19 select the vertical resolution from {240,480,256,480}.
- R6: Command 0x06 loads X1 from data bits 11:0 and X2 from data bits 23:12. The width is the horizontal resolution when X2-X1 is at most 0 or at least 2560. Otherwise it is floor((X2-X1)*hres/2560).
- R7: Command 0x07 loads Y1 from data bits 9:0 and Y2 from data bits 19:10. The height is Y2-Y1, doubled when status bit 19 is set, and is the vertical resolution when that result is at most 0.
- R8: After an accepted command 0x06, 0x07 or 0x08, busy is high in the next cycle. It stays high until the recomputed width and height are on the outputs, which takes at most 14 cycles. An accepted command 0x00 ends any such sequence.
- R9: A command 0x02, 0x03, 0x04, 0x06, 0x07 or 0x08 whose full word equals the last accepted word for that command has no effect: busy stays low and no state changes. Commands 0x00, 0x01, 0x05 and queries always take effect.
- R10: Commands 0x10 to 0x1F load the read-back word from the low nibble of the command word. Nibbles 2 to 5 give environment register n, bits 19:0. Nibble 6 gives environment register 5, bits 19:0. Nibble 7 gives 2. Any other nibble gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Control word write strobe |
| wrData | input | 32 | Control word |
| envRegs | input | 8x32 | Drawing-environment registers for queries |
| statusWord | output | 32 | Packed status register |
| readBack | output | 32 | Query answer register |
| dispX | output | 10 | Display origin X |
| dispY | output | 9 | Display origin Y |
| visWidth | output | 10 | Visible width |
| visHeight | output | 11 | Visible height |
| busy | output | 1 | Geometry recomputation in progress |
| softRstPulse | output | 1 | One-cycle full-reset pulse |
| cmdBufRstPulse | output | 1 | One-cycle command-buffer reset pulse |

## Verification
A wrong duplicate filter shows up on busy in the cycle after the write: it is high when the write should have been dropped, or low when it should have been accepted. A wrong remainder or quotient bit in the divider gives a wrong width at the falling edge of busy, about a dozen cycles after the write. That is why the width cases sit at the threshold edges, use truncating fractions, and use every lookup index that the mode writes reach. Mistakes in status field placement or query selection appear on the status or read-back word one cycle after the write.

// File: rtl/dpy_pkg.sv
package dpy_pkg;
  localparam int RANGE_W   = 12;
  localparam int VRANGE_W  = 10;
  localparam int STARTX_W  = 10;
  localparam int STARTY_W  = 9;
  localparam int HEIGHT_W  = 11;
  localparam int CMD_SLOTS = 9;
  localparam logic [31:0] STATUS_INIT = 32'h1480_2000;

  typedef struct packed {
    logic softRst;
    logic cmdBuf;
    logic setBlank;
    logic setDma;
    logic setStart;
    logic setHRange;
    logic setVRange;
    logic setMode;
    logic query;
    logic divLoad;
    logic divStep;
    logic geoCommit;
  } ctrlStrb_t;

  function automatic logic [9:0] hresOf(input logic [2:0] idx);
    case (idx)
      3'd0: hresOf = 10'd256;
      3'd1: hresOf = 10'd368;
      3'd2: hresOf = 10'd320;
      3'd3: hresOf = 10'd384;
      3'd4, 3'd5: hresOf = 10'd512;
      default: hresOf = 10'd640;
    endcase
  endfunction

  function automatic logic [HEIGHT_W-1:0] vresOf(input logic [1:0] idx);
    case (idx)
      2'd0: vresOf = HEIGHT_W'(240);
      2'd2: vresOf = HEIGHT_W'(256);
      default: vresOf = HEIGHT_W'(480);
    endcase
  endfunction
endpackage

// File: rtl/dpy_ctrl_fsm.sv
module dpy_ctrl_fsm
  import dpy_pkg::*;
#(
  parameter int QUOT_W = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output ctrlStrb_t   strb,
  output logic        busy,
  output logic        softRstPulse,
  output logic        cmdBufRstPulse
);
  localparam int CNT_W = (QUOT_W > 1) ? $clog2(QUOT_W) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_DIV, ST_COMMIT} geoState_t;

  geoState_t state;
  logic [CNT_W-1:0] stepCnt;
  logic [31:0] lastWord [CMD_SLOTS];
  logic [7:0] cmd;
  logic dupHit, accept, geoWr, keepSlot;

  assign cmd = wrData[31:24];
  assign keepSlot = (cmd >= 8'd2) && (cmd < 8'(CMD_SLOTS)) && (cmd != 8'd5);

  always_comb begin
    dupHit = 1'b0;
    if (keepSlot) dupHit = (lastWord[cmd[3:0]] == wrData);
  end

  assign accept = wrEn && !dupHit;

  always_comb begin
    strb = '0;
    strb.softRst   = accept && (cmd == 8'h00);
    strb.cmdBuf    = accept && (cmd <= 8'h01);
    strb.setBlank  = accept && (cmd == 8'h03);
    strb.setDma    = accept && (cmd == 8'h04);
    strb.setStart  = accept && (cmd == 8'h05);
    strb.setHRange = accept && (cmd == 8'h06);
    strb.setVRange = accept && (cmd == 8'h07);
    strb.setMode   = accept && (cmd == 8'h08);
    strb.query     = accept && (cmd[7:4] == 4'h1);
    strb.divLoad   = (state == ST_LOAD);
    strb.divStep   = (state == ST_DIV);
    strb.geoCommit = (state == ST_COMMIT);
  end

  assign geoWr = strb.setHRange || strb.setVRange || strb.setMode;
  assign busy  = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN || strb.softRst) begin
      for (int i = 0; i < CMD_SLOTS; i++) lastWord[i] <= '0;
    end else if (accept && keepSlot) begin
      lastWord[cmd[3:0]] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      stepCnt <= '0;
      softRstPulse <= 1'b0;
      cmdBufRstPulse <= 1'b0;
    end else begin
      softRstPulse <= strb.softRst;
      cmdBufRstPulse <= strb.cmdBuf;
      if (strb.softRst) begin
        state <= ST_IDLE;
      end else if (geoWr) begin
        state <= ST_LOAD;
      end else begin
        case (state)
          ST_LOAD: begin
            state <= ST_DIV;
            stepCnt <= CNT_W'(QUOT_W - 1);
          end
          ST_DIV: begin
            if (stepCnt == '0) state <= ST_COMMIT;
            else stepCnt <= stepCnt - 1'b1;
          end
          ST_COMMIT: state <= ST_IDLE;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R8
  geo_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (geoWr && !strb.softRst) |=> busy);
  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.softRst |=> !busy);
  // R2
  pulse_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    softRstPulse |-> cmdBufRstPulse);
  // R9
  dup_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && dupHit && !busy) |=> !busy);
endmodule

// File: rtl/dpy_ctrl_dp.sv
module dpy_ctrl_dp
  import dpy_pkg::*;
#(
  parameter int HRES_W = 10,
  parameter int SPAN   = 2560,
  parameter int QUOT_W = 10,
  parameter int ENV_N  = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrb_t              strb,
  input  logic [31:0]            wrData,
  input  logic [ENV_N-1:0][31:0] envRegs,
  output logic [31:0]            statusWord,
  output logic [31:0]            readBack,
  output logic [STARTX_W-1:0]    dispX,
  output logic [STARTY_W-1:0]    dispY,
  output logic [HRES_W-1:0]      visWidth,
  output logic [HEIGHT_W-1:0]    visHeight
);
  localparam int PROD_W = RANGE_W + HRES_W;
  localparam logic [PROD_W-1:0] DIV_INIT = PROD_W'(SPAN) << (QUOT_W - 1);

  logic [31:0] statusReg;
  logic [RANGE_W-1:0] x1, x2;
  logic [VRANGE_W-1:0] y1, y2;
  logic [HRES_W-1:0] hRes;
  logic [HEIGHT_W-1:0] vRes;
  logic signed [RANGE_W:0] wDiff;
  logic wFull;
  logic [PROD_W-1:0] prod, remR, divR;
  logic [QUOT_W-1:0] quotR;
  logic signed [VRANGE_W:0] hDiff;
  logic signed [VRANGE_W+1:0] hScaled;
  logic [31:0] queryVal;

  assign hRes = HRES_W'(hresOf(statusReg[18:16]));
  assign vRes = vresOf(statusReg[20:19]);

  assign wDiff = $signed({1'b0, x2}) - $signed({1'b0, x1});
  assign wFull = (wDiff <= 0) || (wDiff >= $signed((RANGE_W+1)'(SPAN)));
  assign prod  = PROD_W'(wDiff[RANGE_W-1:0]) * PROD_W'(hRes);

  assign hDiff   = $signed({1'b0, y2}) - $signed({1'b0, y1});
  assign hScaled = statusReg[19] ? $signed({hDiff, 1'b0})
                                 : $signed({hDiff[VRANGE_W], hDiff});

  always_comb begin
    case (wrData[3:0])
      4'd2, 4'd3, 4'd4, 4'd5: queryVal = {12'h000, envRegs[wrData[2:0]][19:0]};
      4'd6: queryVal = {12'h000, envRegs[5][19:0]};
      4'd7: queryVal = 32'd2;
      default: queryVal = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.softRst) begin
      statusReg <= STATUS_INIT;
      readBack <= '0;
      x1 <= '0; x2 <= '0; y1 <= '0; y2 <= '0;
      dispX <= '0; dispY <= '0;
      visWidth <= HRES_W'(256);
      visHeight <= HEIGHT_W'(240);
      remR <= '0; divR <= '0; quotR <= '0;
    end else begin
      if (strb.setBlank) statusReg[23] <= wrData[0];
      if (strb.setDma) statusReg[30:29] <= wrData[1:0];
      if (strb.setMode) statusReg[22:16] <= {wrData[5:0], wrData[6]};
      if (strb.setStart) begin
        dispX <= wrData[STARTX_W-1:0];
        dispY <= wrData[STARTX_W +: STARTY_W];
      end
      if (strb.setHRange) begin
        x1 <= wrData[RANGE_W-1:0];
        x2 <= wrData[RANGE_W +: RANGE_W];
      end
      if (strb.setVRange) begin
        y1 <= wrData[VRANGE_W-1:0];
        y2 <= wrData[VRANGE_W +: VRANGE_W];
      end
      if (strb.query) readBack <= queryVal;
      if (strb.divLoad) begin
        remR <= prod;
        divR <= DIV_INIT;
        quotR <= '0;
      end else if (strb.divStep) begin
        if (remR >= divR) remR <= remR - divR;
        quotR <= {quotR[QUOT_W-2:0], (remR >= divR)};
        divR <= divR >> 1;
      end
      if (strb.geoCommit) begin
        visWidth <= wFull ? hRes : HRES_W'(quotR);
        visHeight <= (hScaled <= 0) ? vRes : hScaled[HEIGHT_W-1:0];
      end
    end
  end

  assign statusWord = statusReg;

  // R6
  width_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.geoCommit && !strb.softRst) |=> (visWidth <= $past(hRes)));
  // R7
  height_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    visHeight != '0);
  // R4
  start_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.setStart || strb.softRst) |=> $stable({dispX, dispY}));
  // R3
  status_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.setBlank || strb.setDma || strb.setMode || strb.softRst) |=> $stable(statusReg));
endmodule

// File: rtl/dpy_ctrl_dec.sv
module dpy_ctrl_dec
  import dpy_pkg::*;
#(
  parameter int HRES_W = 10,
  parameter int SPAN   = 2560,
  parameter int QUOT_W = 10,
  parameter int ENV_N  = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [31:0]            wrData,
  input  logic [ENV_N-1:0][31:0] envRegs,
  output logic [31:0]            statusWord,
  output logic [31:0]            readBack,
  output logic [STARTX_W-1:0]    dispX,
  output logic [STARTY_W-1:0]    dispY,
  output logic [HRES_W-1:0]      visWidth,
  output logic [HEIGHT_W-1:0]    visHeight,
  output logic                   busy,
  output logic                   softRstPulse,
  output logic                   cmdBufRstPulse
);
  ctrlStrb_t strb;

  dpy_ctrl_fsm #(.QUOT_W(QUOT_W)) u_fsm (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .strb(strb), .busy(busy),
    .softRstPulse(softRstPulse), .cmdBufRstPulse(cmdBufRstPulse)
  );

  dpy_ctrl_dp #(.HRES_W(HRES_W), .SPAN(SPAN), .QUOT_W(QUOT_W), .ENV_N(ENV_N)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .envRegs(envRegs),
    .statusWord(statusWord), .readBack(readBack), .dispX(dispX), .dispY(dispY),
    .visWidth(visWidth), .visHeight(visHeight)
  );
endmodule

// File: tb/dpy_ctrl_dec_test.sv
`timescale 1ns/1ps
module dpy_ctrl_dec_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [7:0][31:0] envRegs;
  logic [31:0] statusWord, readBack;
  logic [9:0] dispX;
  logic [8:0] dispY;
  logic [9:0] visWidth;
  logic [10:0] visHeight;
  logic busy, softRstPulse, cmdBufRstPulse;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dpy_ctrl_dec uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .envRegs(envRegs),
    .statusWord(statusWord), .readBack(readBack), .dispX(dispX), .dispY(dispY),
    .visWidth(visWidth), .visHeight(visHeight), .busy(busy),
    .softRstPulse(softRstPulse), .cmdBufRstPulse(cmdBufRstPulse)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  // one write; returns at the falling edge after the sampling edge
  task automatic wrWord(input logic [31:0] w);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = w;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitIdle(input string tag);
    int n = 0;
    while (busy && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk({tag, " busy released within bound"}, 32'(n <= 14), 32'd1);
  endtask

  function automatic logic [31:0] hWord(input int xa, input int xb);
    return {8'h06, 12'(xb), 12'(xa)};
  endfunction

  function automatic logic [31:0] vWord(input int ya, input int yb);
    return {8'h07, 4'h0, 10'(yb), 10'(ya)};
  endfunction

  task automatic geoCase(input string tag, input logic [31:0] w,
                         input int expW, input int expH);
    wrWord(w);
    chk({tag, " busy after write R8"}, 32'(busy), 32'd1);
    waitIdle(tag);
    chk({tag, " width"}, 32'(visWidth), 32'(expW));
    chk({tag, " height"}, 32'(visHeight), 32'(expH));
  endtask

  task automatic t_reset();
    chk("R1 status", statusWord, 32'h1480_2000);
    chk("R1 readBack", readBack, 32'd0);
    chk("R1 width", 32'(visWidth), 32'd256);
    chk("R1 height", 32'(visHeight), 32'd240);
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 origin", {22'd0, dispX}, 32'd0);
  endtask

  task automatic t_blankDma();
    wrWord(32'h0300_0000);
    chk("R3 blank clear", statusWord, 32'h1400_2000);
    wrWord(32'h0400_0002);
    chk("R3 dma field", statusWord, 32'h5400_2000);
    wrWord(32'h0300_0001);
    chk("R3 blank set", statusWord, 32'h5480_2000);
  endtask

  task automatic t_start();
    wrWord({8'h05, 5'b10101, 9'h1A5, 10'h3FF});
    chk("R4 dispX", {22'd0, dispX}, 32'h3FF);
    chk("R4 dispY", {23'd0, dispY}, 32'h1A5);
    wrWord({8'h05, 5'b00000, 9'h001, 10'h010});
    chk("R4 dispY second", {23'd0, dispY}, 32'h001);
  endtask

  task automatic t_bufPulse();
    wrWord(32'h0100_0000);
    chk("R2 cmdBuf pulse", 32'(cmdBufRstPulse), 32'd1);
    chk("R2 no soft pulse", 32'(softRstPulse), 32'd0);
    chk("R2 status kept", statusWord, 32'h5480_2000);
    @(negedge clk);
    chk("R2 pulse one cycle", 32'(cmdBufRstPulse), 32'd0);
  endtask

  task automatic t_width();
    geoCase("R5 mode hres320", 32'h0800_0001, 320, 240);
    chk("R5 status mode", statusWord, 32'h5482_2000);
    geoCase("R6 frac 320", hWord(500, 2500), 250, 240);
    geoCase("R5 R6 hres368", 32'h0800_0040, 287, 240);
    chk("R5 bit16 from data6", statusWord, 32'h5481_2000);
    geoCase("R6 negative span", hWord(2000, 100), 368, 240);
    geoCase("R5 hres640", 32'h0800_0003, 640, 240);
    chk("R5 status 640", statusWord, 32'h5486_2000);
    geoCase("R6 span 2559", hWord(0, 2559), 639, 240);
    geoCase("R6 span 2560 full", hWord(0, 2560), 640, 240);
  endtask

  task automatic t_height();
    geoCase("R5 back to 320", 32'h0800_0001, 320, 240);
    geoCase("R7 plain", vWord(10, 210), 320, 200);
    geoCase("R7 double", 32'h0800_0005, 320, 400);
    chk("R5 status dh", statusWord, 32'h548A_2000);
    geoCase("R7 zero falls back 480", vWord(5, 5), 320, 480);
    geoCase("R7 mode 240", 32'h0800_0001, 320, 240);
    geoCase("R7 negative falls back", vWord(300, 100), 320, 240);
  endtask

  task automatic t_dedup();
    wrWord(32'h0800_0001);
    chk("R9 dup mode no busy", 32'(busy), 32'd0);
    chk("R9 dup mode status", statusWord, 32'h5482_2000);
    wrWord(vWord(300, 100));
    chk("R9 dup vrange no busy", 32'(busy), 32'd0);
    geoCase("R9 new vrange accepted", vWord(0, 100), 320, 100);
  endtask

  task automatic t_query();
    wrWord(32'h1000_0002);
    chk("R10 nibble2", readBack, {12'd0, envRegs[2][19:0]});
    wrWord(32'h1000_0005);
    chk("R10 nibble5", readBack, {12'd0, envRegs[5][19:0]});
    wrWord(32'h1000_0006);
    chk("R10 nibble6", readBack, {12'd0, envRegs[5][19:0]});
    wrWord(32'h1000_0007);
    chk("R10 nibble7", readBack, 32'd2);
    wrWord(32'h1F00_0003);
    chk("R10 cmd1F nibble3", readBack, {12'd0, envRegs[3][19:0]});
    wrWord(32'h1000_000A);
    chk("R10 nibbleA", readBack, 32'd0);
    wrWord(32'h1000_0002);
    envRegs[2] = 32'hE2F5_A5A5;
    wrWord(32'h1000_0002);
    chk("R9 R10 repeated query", readBack, 32'h0005_A5A5);
  endtask

  task automatic t_softReset();
    wrWord(hWord(100, 900));
    wrWord(32'h0000_0000);
    chk("R2 soft pulse", 32'(softRstPulse), 32'd1);
    chk("R2 cmdBuf with soft", 32'(cmdBufRstPulse), 32'd1);
    chk("R8 R1 busy cleared", 32'(busy), 32'd0);
    t_reset();
  endtask

  initial begin
    for (int i = 0; i < 8; i++)
      envRegs[i] = {8'hE0 + 8'(i), 4'hF, 20'(i * 20'h1A2B3 + 20'h5)};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_blankDma();
    t_start();
    t_bufPulse();
    t_width();
    t_height();
    t_dedup();
    t_query();
    t_softReset();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule